// File: doc/BRIEF.md
# Seven-to-one parallel pixel serializer

The block takes a 28-bit pixel word once per pixel period and spreads it over four serial data lanes, seven bit slots per lane per period. A fifth lane carries a forwarded clock that is high for the first four slots of each period and low for the last three, so its rising edge marks slot 0. The block runs on a bit clock at seven times the pixel rate, which stands in for the phase-locked loop; a one-cycle pixel strobe, phase-aligned to that clock, marks the cycle in which the parallel word is valid.

Each lane carries a fixed, non-sequential subset of the input bits in a fixed slot order, rather than plain bit order. A shutdown input silences every lane at once. After shutdown is released, a programmable number of pixel periods must pass before the link reports ready. Transmission then restarts on a whole period, beginning at slot 0.

Top module: `pix_serializer7`

## Requirements
- R1: The word on `pix_word` is captured in the cycle where the slot counter wraps (a cycle with `pix_stb` high, or the seventh slot of a period). The captured word is sent whole in the next seven slots.
- R2: Slots are sent in the order 0,1,...,6 and then repeat. A `pix_stb` pulse forces the next slot to be 0. The output for slot s appears one bit clock after the counter holds s.
- R3: Lane bit `lane_data[k]` carries these input bits, listed for slots 0 to 6. Lane 0: 1,0,7,6,4,3,2. Lane 1: 9,8,18,15,14,13,12. Lane 2: 20,19,26,25,24,22,21. Lane 3: 5,27,23,17,16,11,10.
- R4: While enabled, `lane_clk` follows the pattern 1111000: it is high in slots 0 to 3 and low in slots 4 to 6, and it rises only at the start of slot 0.
- R5: From the bit clock edge after `shutdown` is sampled high, `lane_oe`, `link_ready`, `lane_clk` and `lane_data` are all 0, and the lock count restarts from zero.
- R6: With `shutdown` low, `link_ready` rises at the LOCK_PIX-th counter wrap. `lane_oe` equals the previous cycle's `link_ready` and not-`shutdown`, so output resumes at slot 0 of a full period.
- R7: While `lane_oe` is 0, `lane_data` and `lane_clk` are 0.
- R8: After reset, every output is 0 and the slot counter is waiting at slot 6.
- R9: Changes on `pix_word` in cycles that are not wrap cycles have no effect on the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_stb | input | 1 | One-cycle pixel strobe that marks the word-valid cycle |
| pix_word | input | 28 | Parallel pixel word |
| shutdown | input | 1 | High silences the link and clears the lock count |
| lane_data | output | 4 | Serial data lanes, one bit per lane per slot |
| lane_clk | output | 1 | Forwarded clock lane, pattern 1111000 |
| lane_oe | output | 1 | Output enable for the data and clock lanes |
| link_ready | output | 1 | Lock reached; lanes carry valid data from the next cycle |

## Verification
A slot counter that slips shows at the ports within one pixel period. The clock-lane pattern loses its 4-high/3-low shape, and every lane shifts bits into the wrong slots, so the scoreboard sees the error on the first affected slot. A wrong lane mapping shows when the first one-hot word is sent, as a bit on the wrong lane or in the wrong slot. A lock counter that is wrong shows as `lane_oe` rising one or more periods early or late, and the bench's own model of the lock delay catches this on the first sample.

// File: rtl/pser_pkg.sv
package pser_pkg;
    parameter int LANES    = 4;
    parameter int SLOTS    = 7;
    parameter int CLK_HIGH = 4;
    localparam int WORD_W  = LANES * SLOTS;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int IDX_W   = $clog2(WORD_W);

    // Source bit of the parallel word for a given lane and slot (R3).
    function automatic logic [IDX_W-1:0] src_bit(input int lane, input int slot);
        int b;
        b = 0;
        case (lane)
            0: case (slot) 0: b = 1;  1: b = 0;  2: b = 7;  3: b = 6;
                           4: b = 4;  5: b = 3;  default: b = 2;  endcase
            1: case (slot) 0: b = 9;  1: b = 8;  2: b = 18; 3: b = 15;
                           4: b = 14; 5: b = 13; default: b = 12; endcase
            2: case (slot) 0: b = 20; 1: b = 19; 2: b = 26; 3: b = 25;
                           4: b = 24; 5: b = 22; default: b = 21; endcase
            default: case (slot) 0: b = 5;  1: b = 27; 2: b = 23; 3: b = 17;
                                 4: b = 16; 5: b = 11; default: b = 10; endcase
        endcase
        return IDX_W'(b);
    endfunction

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] word;
    } seq_state_t;

    typedef struct packed {
        logic [LANES-1:0] data;
        logic             clk;
        logic             oe;
    } lane_out_t;
endpackage

// File: rtl/pser_slot_seq.sv
module pser_slot_seq
    import pser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic [WORD_W-1:0] pix_word,
    output logic [SLOT_W-1:0] slot_o,
    output logic [WORD_W-1:0] word_o,
    output logic              wrap_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    seq_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        wrap = pix_stb || (st_q.slot == LAST);
        st_d = st_q;
        if (wrap) begin
            st_d.slot = '0;
            st_d.word = pix_word;
        end else begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= LAST;
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;
    assign word_o = st_q.word;
    assign wrap_o = wrap;

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == LAST) |=> (st_q.slot == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_stb && st_q.slot != LAST) |=> (st_q.slot == $past(st_q.slot) + SLOT_W'(1)));
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> (st_q.slot == '0) && (st_q.word == $past(pix_word)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_stb && st_q.slot != LAST) |=> $stable(st_q.word));
endmodule

// File: rtl/pser_lane_map.sv
module pser_lane_map
    import pser_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [LANES-1:0]  bits_o,
    output logic              clk_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] idx;
        assign idx       = src_bit(l, int'(slot_i));
        assign bits_o[l] = word_i[idx];
    end

    assign clk_o = (slot_i < SLOT_W'(CLK_HIGH));
endmodule

// File: rtl/pser_link_ctl.sv
module pser_link_ctl #(
    parameter int LOCK_PIX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic shutdown,
    output logic ready_o
);
    localparam int CNT_W = $clog2(LOCK_PIX + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_PIX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } link_state_t;

    link_state_t ls_d, ls_q;

    always_comb begin
        ls_d = ls_q;
        if (shutdown) begin
            ls_d.cnt   = '0;
            ls_d.ready = 1'b0;
        end else if (wrap_i && ls_q.cnt != LIMIT) begin
            ls_d.cnt   = ls_q.cnt + CNT_W'(1);
            ls_d.ready = (ls_q.cnt == LIMIT - CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_q <= '0;
        end else begin
            ls_q <= ls_d;
        end
    end

    assign ready_o = ls_q.ready;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q.cnt <= LIMIT);
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_q.ready && !shutdown) |=> ls_q.ready);
    p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!ls_q.ready && ls_q.cnt == '0));
endmodule

// File: rtl/pix_serializer7.sv
module pix_serializer7
    import pser_pkg::*;
#(
    parameter int LOCK_PIX = 4
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic [WORD_W-1:0] pix_word,
    input  logic              shutdown,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk,
    output logic              lane_oe,
    output logic              link_ready
);
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] word;
    logic              wrap;
    logic [LANES-1:0]  map_bits;
    logic              map_clk;
    logic              ready;
    logic              en;
    lane_out_t         out_d, out_q;

    pser_slot_seq u_seq (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .pix_stb  (pix_stb),
        .pix_word (pix_word),
        .slot_o   (slot),
        .word_o   (word),
        .wrap_o   (wrap)
    );

    pser_lane_map u_map (
        .word_i (word),
        .slot_i (slot),
        .bits_o (map_bits),
        .clk_o  (map_clk)
    );

    pser_link_ctl #(.LOCK_PIX(LOCK_PIX)) u_link (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .shutdown (shutdown),
        .ready_o  (ready)
    );

    always_comb begin
        en        = ready && !shutdown;
        out_d.oe  = en;
        out_d.clk = en ? map_clk  : 1'b0;
        out_d.data = en ? map_bits : '0;
    end

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign lane_data  = out_q.data;
    assign lane_clk   = out_q.clk;
    assign lane_oe    = out_q.oe;
    assign link_ready = ready;

    p_off_quiet_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
        shutdown |=> (!lane_oe && !link_ready && !lane_clk && lane_data == '0));
    p_quiet_r7: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !lane_oe |-> (!lane_clk && lane_data == '0));
    p_oe_follow_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        lane_oe |-> $past(link_ready));
    p_start_slot0_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(lane_oe) |-> ($past(slot) == '0 && lane_clk));
    p_clk_edge_r4: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (lane_oe && $rose(lane_clk)) |-> ($past(slot) == '0));
endmodule

// File: tb/pix_serializer7_tb.sv
`timescale 1ns/100ps
module pix_serializer7_tb;
    localparam int LOCK = 4;

    logic        clk_bit = 1'b0;
    logic        rst_n;
    logic        pix_stb;
    logic [27:0] pix_word;
    logic        shutdown;
    logic [3:0]  lane_data;
    logic        lane_clk;
    logic        lane_oe;
    logic        link_ready;

    pix_serializer7 #(.LOCK_PIX(LOCK)) u_dut (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .pix_stb    (pix_stb),
        .pix_word   (pix_word),
        .shutdown   (shutdown),
        .lane_data  (lane_data),
        .lane_clk   (lane_clk),
        .lane_oe    (lane_oe),
        .link_ready (link_ready)
    );

    always #2.5 clk_bit = ~clk_bit;

    // Source bit per slot (outer index) and lane (inner index), from R3.
    int unsigned tab [7][4] = '{
        '{1, 9, 20, 5}, '{0, 8, 19, 27}, '{7, 18, 26, 23}, '{6, 15, 25, 17},
        '{4, 14, 24, 16}, '{3, 13, 22, 11}, '{2, 12, 21, 10}
    };

    typedef struct packed { logic [3:0] data; logic clk; } item_t;
    item_t exp_q [$];

    int n_chk  = 0;
    int n_fail = 0;
    int bcnt   = 0;
    bit flush_req = 0;
    bit mon_on    = 0;
    bit done      = 0;

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", msg, act, exp);
        end
    endtask

    // Driver: one pixel period. cut>=2 raises shutdown after that edge of the period.
    task automatic send_frame(input logic [27:0] w, input logic sd, input int cut);
        item_t it;
        if (sd && !shutdown) flush_req = 1;
        pix_stb  = 1'b1;
        pix_word = w;
        shutdown = sd;
        if (sd) bcnt = 0;
        else if (bcnt < LOCK) bcnt++;
        @(posedge clk_bit); #1;
        pix_stb  = 1'b0;
        pix_word = 28'($urandom);          // R9: noise outside the wrap cycle
        @(posedge clk_bit); #1;
        check(link_ready == (bcnt == LOCK), "R6 link_ready after wrap", link_ready, bcnt == LOCK);
        if (!sd && bcnt == LOCK) begin
            for (int s = 0; s < 7; s++) begin
                for (int l = 0; l < 4; l++) it.data[l] = w[tab[s][l]];
                it.clk = (s < 4);
                exp_q.push_back(it);
            end
        end
        for (int e = 2; e < 7; e++) begin
            @(posedge clk_bit); #1;
            if (e == cut) begin
                shutdown  = 1'b1;
                flush_req = 1;
                bcnt      = 0;
            end
        end
    endtask

    // Monitor: samples on the falling edge, pops expected items while enabled.
    initial begin
        logic prev_ready, prev_sd;
        item_t it;
        prev_ready = 0;
        prev_sd    = 1;
        forever begin
            @(negedge clk_bit);
            if (mon_on) begin
                check(lane_oe == (prev_ready && !prev_sd), "R6 lane_oe follows ready",
                      lane_oe, prev_ready && !prev_sd);
                check(lane_oe == (exp_q.size() != 0), "R6 enable window", lane_oe, exp_q.size() != 0);
                if (prev_sd)
                    check(!lane_oe && lane_data == 0 && !lane_clk && !link_ready,
                          "R5 shutdown quiet", {lane_oe, lane_data, lane_clk, link_ready}, 0);
                if (!lane_oe)
                    check(lane_data == 0 && !lane_clk, "R7 idle lanes", {lane_data, lane_clk}, 0);
                else if (exp_q.size() != 0) begin
                    it = exp_q.pop_front();
                    check(lane_data == it.data, "R3 R2 R1 R9 lane data", lane_data, it.data);
                    check(lane_clk == it.clk, "R4 clock lane", lane_clk, it.clk);
                end
                if (flush_req) begin
                    exp_q.delete();
                    flush_req = 0;
                end
            end
            prev_ready = link_ready;
            prev_sd    = shutdown;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_bit);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        pix_stb  = 1'b0;
        pix_word = '0;
        shutdown = 1'b1;
        repeat (3) @(negedge clk_bit);
        check(lane_data == 0 && !lane_clk && !lane_oe && !link_ready, "R8 reset state",
              {lane_data, lane_clk, lane_oe, link_ready}, 0);
        @(posedge clk_bit); #1;
        rst_n = 1'b1;
        @(negedge clk_bit);
        check(!lane_oe && !link_ready, "R8 after release", {lane_oe, link_ready}, 0);
        @(posedge clk_bit); #1;
        mon_on = 1;
        for (int i = 0; i < 3; i++) send_frame(28'($urandom), 1'b1, -1);
        // Lock acquisition, then one-hot words exercise every mapping entry (R3).
        for (int i = 0; i < 28; i++) send_frame(28'(1) << i, 1'b0, -1);
        send_frame('1, 1'b0, -1);
        send_frame(28'h5555555, 1'b0, -1);
        send_frame(28'hAAAAAAA, 1'b0, -1);
        for (int i = 0; i < 20; i++) send_frame(28'($urandom), 1'b0, -1);
        // Shutdown in the middle of a period (R5).
        send_frame(28'($urandom), 1'b0, 3);
        for (int i = 0; i < 2; i++) send_frame(28'($urandom), 1'b1, -1);
        for (int i = 0; i < 12; i++) send_frame(28'($urandom), 1'b0, -1);
        // Shutdown on a period boundary, then relock.
        send_frame(28'($urandom), 1'b1, -1);
        for (int i = 0; i < 10; i++) send_frame(28'($urandom), 1'b0, 6 - (i == 9 ? 1 : 7));
        for (int i = 0; i < 8; i++) send_frame(28'($urandom), 1'b0, -1);
        send_frame('0, 1'b1, -1);
        repeat (10) @(posedge clk_bit);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule